// File: doc/BRIEF.md
# SD Host Data Block Sequencer

This block follows the data phase of an SD/MMC host transfer. Software sets up a transfer through a small write-only register port. It loads a start address for single-address DMA, a block size, a boundary code, a block count and a DMA select field. Writing the mode word then starts the transfer. A data-path stub offers fixed-width words in either direction. The sequencer accepts one word per cycle while it is running and not paused. For each accepted word it advances a byte position within the current block. At every block end it decrements the block count, and it decides when the whole transfer is finished.

When DMA is enabled and simple single-address DMA is selected, the DMA address moves forward with each word. The block pauses when the address crosses a power-of-two boundary set by a 3-bit code. In that case it raises a pause status flag. Software resumes the transfer by writing the address register again. When the final block ends, the transfer-complete flag is set. If the mode word asked for it, a one-cycle request for an automatic stop command is also raised. Both status flags are cleared by writing 1 to them.

Top module: `sdx_xfer_seq`

## Requirements
- R1: After reset `busy_o`, `paused_o`, `word_ready_o`, `auto_stop_o`, `status_o`, `dma_addr_o` and `blocks_left_o` are all zero.
- R2: Register select 0 loads the DMA address. Select 1 loads the geometry: block size in bytes from bits [11:0] and boundary code from bits [14:12]. Select 2 loads the block count. Select 3 writes the mode word and starts a transfer. Select 4 loads the DMA select in bits [1:0]. Select 5 clears status bits. The mode bits are: bit 0 DMA enable, bit 1 count enable, bit 2 auto-stop, bit 4 direction, bit 5 multi-block. `read_dir_o` shows mode bit 4 (1 = card to host).
- R3: `word_ready_o` is high only while a transfer runs and is not paused. Each accepted word adds 4 bytes to the position in the block. A block ends on the word that brings the position to the block size. Words offered while not ready change nothing.
- R4: With count enable set, `blocks_left_o` drops by one at each block end and never goes below zero. A multi-block transfer with counting ends when the count reaches zero.
- R5: In single-block mode (bit 5 = 0) the transfer ends after one block, whatever the count holds.
- R6: In multi-block mode without count enable, the transfer keeps running across block ends, and the count is left untouched.
- R7: With DMA enabled and DMA select 00, `dma_addr_o` grows by 4 per accepted word. With any other select, or with DMA disabled, it does not move.
- R8: The boundary is 4096 << code bytes. If an address step changes the address bits at or above that size, the block pauses and sets `status_o[3]`. A word that also finishes the transfer does not pause.
- R9: A write to register 0 while paused clears the pause, and word transfer resumes from the written address.
- R10: The word that ends the final block sets `status_o[1]` and clears `busy_o`.
- R11: `auto_stop_o` is high for exactly the one cycle after the final word of a multi-block transfer, and only if mode bit 2 was set.
- R12: A write to register 5 clears status bit 1 and/or bit 3 where the written bit is 1. A 0 leaves the bit unchanged.
- R13: A mode write with count enable and multi-block set while the block count is zero does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| word_valid_i | input | 1 | Data-path stub offers a word |
| word_ready_o | output | 1 | Sequencer accepts a word this cycle |
| busy_o | output | 1 | Transfer in progress |
| paused_o | output | 1 | Held at a DMA boundary |
| read_dir_o | output | 1 | Direction: 1 = card to host |
| dma_addr_o | output | 32 | Current DMA byte address |
| blocks_left_o | output | 16 | Remaining block count |
| status_o | output | 4 | Bit 1 transfer complete, bit 3 boundary pause; others 0 |
| auto_stop_o | output | 1 | One-cycle automatic stop request |

## Verification
A register write takes effect at the rising edge where the strobe is present. An accepted word changes the address, position, count and status at that same edge. The auto-stop pulse is visible only for the cycle that follows the finishing edge. The bench drives every input just after a falling edge. It reads results at the next falling edge, which is half a cycle after the edge that updated them. The one-cycle stop pulse is therefore sampled once while high and once more a cycle later to see it gone.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    typedef struct packed {
        logic multi;
        logic rd;
        logic auto_stop;
        logic cnt_en;
        logic dma_en;
    } xfer_mode_t;

    localparam logic [2:0] SEL_ADDR  = 3'd0;
    localparam logic [2:0] SEL_GEOM  = 3'd1;
    localparam logic [2:0] SEL_COUNT = 3'd2;
    localparam logic [2:0] SEL_MODE  = 3'd3;
    localparam logic [2:0] SEL_DSEL  = 3'd4;
    localparam logic [2:0] SEL_STAT  = 3'd5;

    localparam int DONE_BIT  = 1;
    localparam int PAUSE_BIT = 3;

endpackage

// File: rtl/sdx_mode_dec.sv
module sdx_mode_dec
    import sdx_pkg::*;
(
    input  logic [4:0]  raw_bits,   // {bit5, bit4, bit2, bit1, bit0} of the mode word
    output xfer_mode_t  mode
);
    always_comb begin
        mode.dma_en    = raw_bits[0];
        mode.cnt_en    = raw_bits[1];
        mode.auto_stop = raw_bits[2];
        mode.rd        = raw_bits[3];
        mode.multi     = raw_bits[4];
    end
endmodule

// File: rtl/sdx_bound_det.sv
module sdx_bound_det #(
    parameter int ADDR_W     = 32,
    parameter int CODE_W     = 3,
    parameter int BASE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] nxt_addr,
    input  logic [CODE_W-1:0] code,
    output logic              crossed
);
    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff    = (cur_addr ^ nxt_addr) >> (BASE_SHIFT + int'(code));
        crossed = |diff;
    end
endmodule

// File: rtl/sdx_xfer_seq.sv
module sdx_xfer_seq
    import sdx_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int SIZE_W     = 12,
    parameter int CODE_W     = 3,
    parameter int DSEL_W     = 2,
    parameter int WORD_BYTES = 4,
    parameter int BASE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    input  logic              word_valid_i,
    output logic              word_ready_o,
    output logic              busy_o,
    output logic              paused_o,
    output logic              read_dir_o,
    output logic [ADDR_W-1:0] dma_addr_o,
    output logic [CNT_W-1:0]  blocks_left_o,
    output logic [3:0]        status_o,
    output logic              auto_stop_o
);
    localparam int LEN_W = SIZE_W + 1;
    localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(WORD_BYTES);
    localparam logic [SIZE_W-1:0] STEP_S = SIZE_W'(WORD_BYTES);
    localparam logic [LEN_W-1:0]  STEP_L = LEN_W'(WORD_BYTES);
    localparam logic [CNT_W-1:0]  ONE_C  = CNT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] size;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  count;
        xfer_mode_t        mode;
        logic [DSEL_W-1:0] dsel;
        logic [SIZE_W-1:0] in_blk;
        logic              busy;
        logic              paused;
        logic              st_done;
        logic              st_pause;
        logic              stop;
    } seq_state_t;

    seq_state_t s_d, s_q;

    xfer_mode_t        mode_new;
    logic [ADDR_W-1:0] addr_step;
    logic              crossed;
    logic              take;
    logic              dma_on;
    logic              blk_end;
    logic              finish;

    sdx_mode_dec u_dec (
        .raw_bits ({reg_wdata[5], reg_wdata[4], reg_wdata[2:0]}),
        .mode     (mode_new)
    );

    sdx_bound_det #(
        .ADDR_W     (ADDR_W),
        .CODE_W     (CODE_W),
        .BASE_SHIFT (BASE_SHIFT)
    ) u_bound (
        .cur_addr (s_q.addr),
        .nxt_addr (addr_step),
        .code     (s_q.code),
        .crossed  (crossed)
    );

    always_comb begin
        addr_step = s_q.addr + STEP_A;
        take      = s_q.busy && !s_q.paused && word_valid_i;
        dma_on    = s_q.mode.dma_en && (s_q.dsel == '0);
        blk_end   = ({1'b0, s_q.in_blk} + STEP_L) >= {1'b0, s_q.size};
        finish    = blk_end &&
                    (!s_q.mode.multi || (s_q.mode.cnt_en && s_q.count == ONE_C));

        s_d      = s_q;
        s_d.stop = 1'b0;

        if (reg_we) begin
            case (reg_addr)
                SEL_ADDR: begin
                    s_d.addr   = reg_wdata;
                    s_d.paused = 1'b0;
                end
                SEL_GEOM: begin
                    s_d.size = reg_wdata[SIZE_W-1:0];
                    s_d.code = reg_wdata[SIZE_W +: CODE_W];
                end
                SEL_COUNT: s_d.count = reg_wdata[CNT_W-1:0];
                SEL_MODE: begin
                    s_d.mode   = mode_new;
                    s_d.in_blk = '0;
                    s_d.paused = 1'b0;
                    s_d.busy   = !(mode_new.cnt_en && mode_new.multi && s_q.count == '0);
                end
                SEL_DSEL: s_d.dsel = reg_wdata[DSEL_W-1:0];
                SEL_STAT: begin
                    if (reg_wdata[DONE_BIT])  s_d.st_done  = 1'b0;
                    if (reg_wdata[PAUSE_BIT]) s_d.st_pause = 1'b0;
                end
                default: ;
            endcase
        end

        if (take) begin
            if (dma_on) s_d.addr = addr_step;
            if (blk_end) begin
                s_d.in_blk = '0;
                if (s_q.mode.cnt_en && s_q.count != '0) s_d.count = s_q.count - ONE_C;
                if (finish) begin
                    s_d.busy    = 1'b0;
                    s_d.st_done = 1'b1;
                    s_d.stop    = s_q.mode.multi && s_q.mode.auto_stop;
                end
            end else begin
                s_d.in_blk = s_q.in_blk + STEP_S;
            end
            if (dma_on && crossed && !finish) begin
                s_d.paused   = 1'b1;
                s_d.st_pause = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_ready_o  = s_q.busy && !s_q.paused;
    assign busy_o        = s_q.busy;
    assign paused_o      = s_q.paused;
    assign read_dir_o    = s_q.mode.rd;
    assign dma_addr_o    = s_q.addr;
    assign blocks_left_o = s_q.count;
    assign status_o      = {s_q.st_pause, 1'b0, s_q.st_done, 1'b0};
    assign auto_stop_o   = s_q.stop;

    // R11
    stop_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_stop_o |-> (status_o[DONE_BIT] && !busy_o));
    // R11
    stop_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        auto_stop_o |=> !auto_stop_o);
    // R8
    pause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(paused_o) |-> status_o[PAUSE_BIT]);
    // R8
    pause_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        paused_o |-> busy_o);
    // R4
    count_down_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> (blocks_left_o <= $past(blocks_left_o)));
    // R10
    done_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[DONE_BIT]) |-> $fell(busy_o));
    // R3
    idle_no_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_ready_o && !reg_we) |=> ($stable(dma_addr_o) && $stable(blocks_left_o)));

endmodule

// File: tb/tb_sdx_xfer_seq.sv
`timescale 1ns/1ps
module tb_sdx_xfer_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        word_valid_i = 1'b0;
    logic        word_ready_o, busy_o, paused_o, read_dir_o, auto_stop_o;
    logic [31:0] dma_addr_o;
    logic [15:0] blocks_left_o;
    logic [3:0]  status_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit stop_seen;

    always #2.5 clk = ~clk;

    sdx_xfer_seq dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .word_valid_i(word_valid_i),
        .word_ready_o(word_ready_o), .busy_o(busy_o), .paused_o(paused_o),
        .read_dir_o(read_dir_o), .dma_addr_o(dma_addr_o),
        .blocks_left_o(blocks_left_o), .status_o(status_o),
        .auto_stop_o(auto_stop_o)
    );

    typedef struct packed {
        logic [11:0] size;
        logic [2:0]  code;
        logic [15:0] cnt;
        logic [5:0]  mode;
        logic [31:0] addr;
        logic [7:0]  nw;
        logic        ebusy;
        logic        edone;
        logic        epause;
        logic [15:0] eleft;
        logic [31:0] eaddr;
        logic        estop;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        // R4 R11: 3 blocks of 16 B, count on, auto-stop on
        '{12'd16, 3'd0, 16'd3, 6'h27, 32'h1000,  8'd12, 1'b0, 1'b1, 1'b0, 16'd0, 32'h1030,  1'b1},
        // R11: same without auto-stop
        '{12'd16, 3'd0, 16'd3, 6'h23, 32'h4000,  8'd12, 1'b0, 1'b1, 1'b0, 16'd0, 32'h4030,  1'b0},
        // R5: single block, count 5, auto-stop bit ignored
        '{12'd8,  3'd0, 16'd5, 6'h17, 32'h2000,  8'd2,  1'b0, 1'b1, 1'b0, 16'd4, 32'h2008,  1'b0},
        // R6: multi, no counting, keeps running
        '{12'd8,  3'd0, 16'd2, 6'h31, 32'h3000,  8'd6,  1'b1, 1'b0, 1'b0, 16'd2, 32'h3018,  1'b0},
        // R3: partial block in progress
        '{12'd16, 3'd0, 16'd2, 6'h23, 32'h5000,  8'd5,  1'b1, 1'b0, 1'b0, 16'd1, 32'h5014,  1'b0},
        // R7: DMA disabled, address frozen
        '{12'd8,  3'd0, 16'd2, 6'h22, 32'h6000,  8'd4,  1'b0, 1'b1, 1'b0, 16'd0, 32'h6000,  1'b0},
        // R8: 4 KiB boundary crossed -> pause
        '{12'd16, 3'd0, 16'd2, 6'h23, 32'h0FF8,  8'd2,  1'b1, 1'b0, 1'b1, 16'd2, 32'h1000,  1'b0},
        // R8: 8 KiB boundary not crossed
        '{12'd16, 3'd1, 16'd2, 6'h23, 32'h0FF8,  8'd2,  1'b1, 1'b0, 1'b0, 16'd2, 32'h1000,  1'b0},
        // R8 R10: 512 KiB crossed on the finishing word -> complete, no pause
        '{12'd8,  3'd7, 16'd1, 6'h23, 32'h7FFF8, 8'd2,  1'b0, 1'b1, 1'b0, 16'd0, 32'h80000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic push(input int n);
        stop_seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            word_valid_i = 1'b1;
            @(negedge clk);
            if (auto_stop_o) stop_seen = 1'b1;
        end
        word_valid_i = 1'b0;
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy_o}, 32'd0);
        chk("R1 ready", {31'd0, word_ready_o}, 32'd0);
        chk("R1 status", {28'd0, status_o}, 32'd0);
        chk("R1 addr", dma_addr_o, 32'd0);
        chk("R1 left", {16'd0, blocks_left_o}, 32'd0);
        chk("R1 stop", {31'd0, auto_stop_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 9; v++) begin
            wr(3'd5, 32'hA);
            wr(3'd0, VECS[v].addr);
            wr(3'd1, {17'd0, VECS[v].code, VECS[v].size});
            wr(3'd2, {16'd0, VECS[v].cnt});
            wr(3'd3, {26'd0, VECS[v].mode});
            push(int'(VECS[v].nw));
            chk("R10 busy", {31'd0, busy_o}, {31'd0, VECS[v].ebusy});
            chk("R10 done", {31'd0, status_o[1]}, {31'd0, VECS[v].edone});
            chk("R8 pause", {31'd0, status_o[3]}, {31'd0, VECS[v].epause});
            chk("R4 left", {16'd0, blocks_left_o}, {16'd0, VECS[v].eleft});
            chk("R7 addr", dma_addr_o, VECS[v].eaddr);
            chk("R11 stop", {31'd0, stop_seen}, {31'd0, VECS[v].estop});
        end

        // R9 resume after a boundary pause
        wr(3'd5, 32'hA);
        wr(3'd0, 32'h1FF8);
        wr(3'd1, {17'd0, 3'd0, 12'd16});
        wr(3'd2, 32'd2);
        wr(3'd3, 32'h23);
        push(2);
        chk("R8 paused", {31'd0, paused_o}, 32'd1);
        chk("R3 ready while paused", {31'd0, word_ready_o}, 32'd0);
        push(1);
        chk("R3 word ignored while paused", dma_addr_o, 32'h2000);
        wr(3'd0, 32'h2000);
        chk("R9 resumed", {31'd0, paused_o}, 32'd0);
        push(6);
        chk("R9 done after resume", {31'd0, status_o[1]}, 32'd1);
        chk("R9 left", {16'd0, blocks_left_o}, 32'd0);
        chk("R9 addr", dma_addr_o, 32'h2018);

        // R12 write-1-to-clear
        chk("R12 both set", {28'd0, status_o}, 32'hA);
        wr(3'd5, 32'h0);
        chk("R12 zero write", {28'd0, status_o}, 32'hA);
        wr(3'd5, 32'h2);
        chk("R12 clear done", {28'd0, status_o}, 32'h8);
        wr(3'd5, 32'h8);
        chk("R12 clear pause", {28'd0, status_o}, 32'h0);

        // R7 non-simple DMA select: no address movement, no pause
        wr(3'd4, 32'd1);
        wr(3'd0, 32'h0FF8);
        wr(3'd1, {17'd0, 3'd0, 12'd8});
        wr(3'd2, 32'd2);
        wr(3'd3, 32'h23);
        push(2);
        chk("R7 addr frozen", dma_addr_o, 32'h0FF8);
        chk("R8 no pause", {31'd0, paused_o}, 32'd0);
        wr(3'd4, 32'd0);

        // R13 zero count with counting in multi-block
        wr(3'd2, 32'd0);
        wr(3'd3, 32'h23);
        chk("R13 not started", {31'd0, busy_o}, 32'd0);
        chk("R13 not ready", {31'd0, word_ready_o}, 32'd0);
        // R5 single block starts even with zero count
        wr(3'd3, 32'h03);
        chk("R5 started", {31'd0, busy_o}, 32'd1);
        push(2);
        chk("R5 ended", {31'd0, busy_o}, 32'd0);
        chk("R4 no underflow", {16'd0, blocks_left_o}, 32'd0);

        // R2 direction bit
        wr(3'd3, 32'h13);
        chk("R2 read dir", {31'd0, read_dir_o}, 32'd1);
        wr(3'd3, 32'h03);
        chk("R2 write dir", {31'd0, read_dir_o}, 32'd0);

        // R11 pulse width
        wr(3'd1, {17'd0, 3'd0, 12'd4});
        wr(3'd2, 32'd1);
        wr(3'd3, 32'h27);
        push(1);
        chk("R11 pulse high", {31'd0, auto_stop_o}, 32'd1);
        @(negedge clk);
        chk("R11 pulse gone", {31'd0, auto_stop_o}, 32'd0);

        report();
    end

endmodule